// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Sequencer

This block sits beside the main command scheduler of a DDR3-style memory controller and owns the command pins of one rank whenever a refresh is due. On a refresh request it closes any open rows, waits the row-precharge time, and then issues one or more auto-refresh commands. Each refresh is followed by a window in which only idle commands reach the bus. On a self-refresh request it closes the rows in the same way and drops the clock-enable on a refresh command, so the rank keeps its own contents with no clocking. It leaves that state when asked to and then observes the exit recovery time.

The scheduler sees a `busy` level and a same-cycle `grant` pulse. It also sees two permissions: `act_ok` (a row may be opened) and `wr_ok` (a write may be sent). After self-refresh, writes stay locked until the reference voltage has been valid for a parameterised number of clocks. Requests that arrive while the sequencer is working are remembered and served later. All timings are parameters counted in clock cycles.

Top module: `dram_rfsh_seq`

## Requirements
- R1: When any bank is open at grant, the first command is a PRECHARGE (pins L L H L). A10 is high if two or more banks are open. With exactly one bank open, A10 is low and the bank address is that bank's index (single-bank variant, the default). The open-bank vector is sampled on the grant cycle.
- R2: The first REFRESH (pins L L L H) comes exactly TRP cycles after the PRECHARGE. If no bank was open, it comes on the cycle after grant.
- R3: After every REFRESH the pins carry only NOP or DES for TRFC cycles. A burst of N refreshes (N taken from the burst input at grant, 0 meaning 1) puts them exactly TRFC cycles apart. `busy` falls TRFC cycles after the last one.
- R4: CKE is high on every PRECHARGE cycle and on every auto-refresh REFRESH cycle.
- R5: Pin encodings are NOP = L H H H and DES = CS# high. NOP is driven while idle and in every waiting cycle outside self-refresh.
- R6: Self-refresh entry closes open banks as in R1 and R2, then issues the REFRESH encoding with CKE low. It then holds CKE low with DES until an exit request.
- R7: An exit request in self-refresh raises CKE and drives NOP for TXS cycles. After that, `busy` falls and `act_ok` rises. An exit request outside self-refresh has no effect.
- R8: From self-refresh entry, `wr_ok` stays low until the reference-valid input has been high for WR_LOCK consecutive clocks. The count restarts whenever that input is low. `wr_ok` is also never high while `act_ok` is low. Outside self-refresh, the reference-valid input has no effect.
- R9: A refresh or self-refresh request raised while busy is held and served when the sequencer returns to idle. A pending refresh is served before a pending self-refresh.
- R10: After reset the block is idle: CKE high, NOP on the pins, `busy` low, `act_ok` and `wr_ok` high.
- R11: `grant` is high, combinationally, in the idle cycle in which a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rfsh_req_i | input | 1 | Auto-refresh request |
| rfsh_burst_i | input | BURST_W | Number of refreshes in the burst, 0 means 1 |
| sr_enter_i | input | 1 | Self-refresh entry request |
| sr_exit_i | input | 1 | Self-refresh exit request |
| open_banks_i | input | NBANK | One bit per bank with an open row |
| vref_ok_i | input | 1 | Reference voltage valid |
| busy_o | output | 1 | Sequencer owns the command bus |
| grant_o | output | 1 | Request accepted this cycle |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable |
| a10_o | output | 1 | All-bank select during precharge |
| ba_o | output | BA_W | Bank address |
| act_ok_o | output | 1 | Row activation permitted |
| wr_ok_o | output | 1 | Writes permitted |

## Verification
The assertions assume that the scheduler leaves the open-bank vector alone between grant and the precharge. They also assume an exit request only while CKE is low, and that timing parameters are at least two cycles. The bench changes `open_banks_i` only on grant cycles. It raises `sr_exit_i` only once self-refresh is reached, except for a single probe while idle, which the block must ignore. Every stimulus edge is driven on the falling clock edge, so request timing is never ambiguous.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_PRE, ST_WRP, ST_REF, ST_WRFC, ST_SRE, ST_SELF, ST_SRX
   } seq_st_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } cmd_pins_t;

   localparam cmd_pins_t PINS_NOP = 4'b0111;
   localparam cmd_pins_t PINS_PRE = 4'b0010;
   localparam cmd_pins_t PINS_REF = 4'b0001;
   localparam cmd_pins_t PINS_DES = 4'b1111;
endpackage

// File: rtl/rfsh_wait_ctr.sv
module rfsh_wait_ctr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt_q <= '0;
      else if (load_i)      cnt_q <= val_i;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/rfsh_bank_sel.sv
module rfsh_bank_sel #(
   parameter int NBANK           = 8,
   parameter bit SINGLE_BANK_PRE = 1'b1,
   localparam int BA_W           = $clog2(NBANK)
) (
   input  logic [NBANK-1:0] banks_i,
   output logic             any_o,
   output logic             a10_o,
   output logic [BA_W-1:0]  ba_o
);
   assign any_o = |banks_i;

   if (SINGLE_BANK_PRE) begin : g_single
      always_comb begin
         ba_o = '0;
         for (int i = NBANK - 1; i >= 0; i--)
            if (banks_i[i]) ba_o = i[BA_W-1:0];
      end
      assign a10_o = ($countones(banks_i) > 1);
   end else begin : g_all
      assign ba_o  = '0;
      assign a10_o = 1'b1;
   end
endmodule

// File: rtl/rfsh_wr_lock.sv
module rfsh_wr_lock #(
   parameter int WR_LOCK = 512,
   localparam int CW     = $clog2(WR_LOCK + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic vref_ok_i,
   output logic locked_o
);
   logic [CW-1:0] cnt_q;
   logic          locked_q;
   logic          done;

   assign done = locked_q && vref_ok_i && (cnt_q == CW'(WR_LOCK - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
         cnt_q    <= '0;
      end else if (arm_i) begin
         locked_q <= 1'b1;
         cnt_q    <= '0;
      end else if (locked_q) begin
         if (!vref_ok_i) cnt_q <= '0;
         else            cnt_q <= cnt_q + 1'b1;
         if (done)       locked_q <= 1'b0;
      end
   end

   assign locked_o = locked_q;

   // R8: a low reference keeps the lock in place
   p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_q && !vref_ok_i) |=> locked_q);
endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
   import dram_rfsh_pkg::*;
#(
   parameter int NBANK           = 8,
   parameter int BURST_W         = 3,
   parameter int TRP             = 3,
   parameter int TRFC            = 8,
   parameter int TXS             = 5,
   parameter int WR_LOCK         = 512,
   parameter bit SINGLE_BANK_PRE = 1'b1,
   localparam int BA_W           = $clog2(NBANK)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rfsh_req_i,
   input  logic [BURST_W-1:0] rfsh_burst_i,
   input  logic               sr_enter_i,
   input  logic               sr_exit_i,
   input  logic [NBANK-1:0]   open_banks_i,
   input  logic               vref_ok_i,
   output logic               busy_o,
   output logic               grant_o,
   output logic               cs_n_o,
   output logic               ras_n_o,
   output logic               cas_n_o,
   output logic               we_n_o,
   output logic               cke_o,
   output logic               a10_o,
   output logic [BA_W-1:0]    ba_o,
   output logic               act_ok_o,
   output logic               wr_ok_o
);
   localparam int TMAX = (TRFC > TRP) ? ((TRFC > TXS) ? TRFC : TXS) : ((TRP > TXS) ? TRP : TXS);
   localparam int CW   = $clog2(TMAX + 1);

   if (TRP < 2)   begin : g_bad_trp  $error("TRP must be at least 2");  end
   if (TRFC < 2)  begin : g_bad_trfc $error("TRFC must be at least 2"); end
   if (TXS < 1)   begin : g_bad_txs  $error("TXS must be at least 1");  end
   if (NBANK < 2) begin : g_bad_nb   $error("NBANK must be at least 2"); end

   seq_st_e            st_q, st_d;
   logic               rf_pend_q, sr_pend_q, sr_mode_q, sr_mode_d;
   logic [BURST_W-1:0] rem_q, rem_d;
   logic               a10_q;
   logic [BA_W-1:0]    ba_q;
   logic               take_rf, take_sr, grant;
   logic               sel_any, sel_a10;
   logic [BA_W-1:0]    sel_ba;
   logic               ld;
   logic [CW-1:0]      ld_val;
   logic               tmr_zero, locked;
   cmd_pins_t          pins;

   rfsh_bank_sel #(.NBANK(NBANK), .SINGLE_BANK_PRE(SINGLE_BANK_PRE)) u_sel (
      .banks_i(open_banks_i), .any_o(sel_any), .a10_o(sel_a10), .ba_o(sel_ba));

   rfsh_wait_ctr #(.W(CW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load_i(ld), .val_i(ld_val), .zero_o(tmr_zero));

   rfsh_wr_lock #(.WR_LOCK(WR_LOCK)) u_lock (
      .clk(clk), .rst_n(rst_n), .arm_i(st_q == ST_SRE),
      .vref_ok_i(vref_ok_i), .locked_o(locked));

   assign take_rf = rfsh_req_i | rf_pend_q;
   assign take_sr = sr_enter_i | sr_pend_q;
   assign grant   = (st_q == ST_IDLE) && (take_rf || take_sr);

   always_comb begin
      st_d      = st_q;
      sr_mode_d = sr_mode_q;
      rem_d     = rem_q;
      ld        = 1'b0;
      ld_val    = '0;
      unique case (st_q)
         ST_IDLE: if (grant) begin
            sr_mode_d = !take_rf;
            rem_d     = (rfsh_burst_i == '0) ? BURST_W'(1) : rfsh_burst_i;
            st_d      = sel_any ? ST_PRE : (take_rf ? ST_REF : ST_SRE);
         end
         ST_PRE:  begin ld = 1'b1; ld_val = CW'(TRP - 2); st_d = ST_WRP; end
         ST_WRP:  if (tmr_zero) st_d = sr_mode_q ? ST_SRE : ST_REF;
         ST_REF:  begin
            ld = 1'b1; ld_val = CW'(TRFC - 2);
            rem_d = rem_q - 1'b1; st_d = ST_WRFC;
         end
         ST_WRFC: if (tmr_zero) st_d = (rem_q != '0) ? ST_REF : ST_IDLE;
         ST_SRE:  st_d = ST_SELF;
         ST_SELF: if (sr_exit_i) begin ld = 1'b1; ld_val = CW'(TXS - 1); st_d = ST_SRX; end
         ST_SRX:  if (tmr_zero) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         rf_pend_q <= 1'b0;
         sr_pend_q <= 1'b0;
         sr_mode_q <= 1'b0;
         rem_q     <= '0;
         a10_q     <= 1'b0;
         ba_q      <= '0;
      end else begin
         st_q      <= st_d;
         sr_mode_q <= sr_mode_d;
         rem_q     <= rem_d;
         rf_pend_q <= take_rf && !(grant && take_rf);
         sr_pend_q <= take_sr && !(grant && !take_rf);
         if (grant) begin
            a10_q <= sel_a10;
            ba_q  <= sel_ba;
         end
      end
   end

   always_comb begin
      pins  = PINS_NOP;
      cke_o = 1'b1;
      a10_o = 1'b0;
      ba_o  = '0;
      unique case (st_q)
         ST_PRE:  begin pins = PINS_PRE; a10_o = a10_q; ba_o = ba_q; end
         ST_REF:  pins = PINS_REF;
         ST_SRE:  begin pins = PINS_REF; cke_o = 1'b0; end
         ST_SELF: begin pins = PINS_DES; cke_o = 1'b0; end
         default: pins = PINS_NOP;
      endcase
   end

   assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = pins;
   assign busy_o   = (st_q != ST_IDLE);
   assign grant_o  = grant;
   assign act_ok_o = (st_q == ST_IDLE);
   assign wr_ok_o  = act_ok_o && !locked;

   // Checker state: cycles since the last PRECHARGE and REFRESH on the pins
   localparam int RW = $clog2(TRFC + 1);
   localparam int PW = $clog2(TRP + 1);
   logic          is_pre, is_ref, is_quiet;
   logic [RW-1:0] since_ref_q;
   logic [PW-1:0] since_pre_q;

   assign is_pre   = !cs_n_o && !ras_n_o && cas_n_o && !we_n_o;
   assign is_ref   = !cs_n_o && !ras_n_o && !cas_n_o && we_n_o;
   assign is_quiet = cs_n_o || (ras_n_o && cas_n_o && we_n_o);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_ref_q <= RW'(TRFC);
         since_pre_q <= PW'(TRP);
      end else begin
         if (is_ref)                       since_ref_q <= RW'(1);
         else if (since_ref_q != RW'(TRFC)) since_ref_q <= since_ref_q + 1'b1;
         if (is_pre)                       since_pre_q <= PW'(1);
         else if (since_pre_q != PW'(TRP))  since_pre_q <= since_pre_q + 1'b1;
      end
   end

   p_pre_a10_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pre && !a10_o) |-> $onehot($past(open_banks_i)));
   p_rp_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      is_ref |-> (since_pre_q >= PW'(TRP)));
   p_rfc_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (since_ref_q < RW'(TRFC)) |-> is_quiet);
   p_cke_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> cke_o);
   p_sr_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke_o) |-> is_ref);
   p_wr_act_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok_o |-> act_ok_o);
endmodule

// File: tb/dram_rfsh_seq_bench.sv
module dram_rfsh_seq_bench;
   localparam int PERIOD = 10;
   localparam int TRP = 3, TRFC = 8, TXS = 5, WRL = 512, NB = 8, BW = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic rreq = 1'b0, sre = 1'b0, srx = 1'b0, vref = 1'b1;
   logic [BW-1:0] burst = '0;
   logic [NB-1:0] banks = '0;
   logic busy, grant, cs_n, ras_n, cas_n, we_n, cke, a10, act_ok, wr_ok;
   logic [2:0] ba;
   int checks = 0, errors = 0;

   localparam int P_NOP = 4'b0111, P_PRE = 4'b0010, P_REF = 4'b0001;

   dram_rfsh_seq #(.NBANK(NB), .BURST_W(BW), .TRP(TRP), .TRFC(TRFC),
                   .TXS(TXS), .WR_LOCK(WRL)) u_dram_rfsh_seq (
      .clk(clk), .rst_n(rst_n), .rfsh_req_i(rreq), .rfsh_burst_i(burst),
      .sr_enter_i(sre), .sr_exit_i(srx), .open_banks_i(banks), .vref_ok_i(vref),
      .busy_o(busy), .grant_o(grant), .cs_n_o(cs_n), .ras_n_o(ras_n),
      .cas_n_o(cas_n), .we_n_o(we_n), .cke_o(cke), .a10_o(a10), .ba_o(ba),
      .act_ok_o(act_ok), .wr_ok_o(wr_ok));

   always #(PERIOD/2) clk = ~clk;

   task automatic chk(input string r, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
      end
   endtask

   function automatic int pins();
      return int'({cs_n, ras_n, cas_n, we_n});
   endfunction

   task automatic step();
      @(negedge clk);
   endtask

   task automatic run_rf(input logic [NB-1:0] bk, input int bu);
      int n  = (bu == 0) ? 1 : bu;
      bit p  = (bk != '0);
      int fr = p ? 1 + TRP : 1;
      int last = fr + n * TRFC;
      int lo = 0;
      for (int i = NB - 1; i >= 0; i--) if (bk[i]) lo = i;
      step(); banks = bk; burst = BW'(bu); rreq = 1'b1;
      #1 chk("R11 grant on accept", int'(grant), 1);
      for (int k = 1; k <= last; k++) begin
         int e;
         step(); rreq = 1'b0;
         if (p && k == 1) e = P_PRE;
         else if (k >= fr && (k - fr) % TRFC == 0 && (k - fr) / TRFC < n) e = P_REF;
         else e = P_NOP;
         chk($sformatf("R1/R2/R3/R5 pins bk=%0h bu=%0d k=%0d", bk, bu, k), pins(), e);
         if (e != P_NOP) chk("R4 cke on command", int'(cke), 1);
         if (e == P_PRE) begin
            chk("R1 a10", int'(a10), int'($countones(bk) > 1));
            if ($countones(bk) == 1) chk("R1 bank index", int'(ba), lo);
         end
         chk($sformatf("R3 busy k=%0d", k), int'(busy), int'(k < last));
      end
   endtask

   initial begin
      #(PERIOD * 200000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R10: reset state
      chk("R10 cke", int'(cke), 1);
      chk("R10 pins NOP", pins(), P_NOP);
      chk("R10 busy", int'(busy), 0);
      chk("R10 act_ok", int'(act_ok), 1);
      chk("R10 wr_ok", int'(wr_ok), 1);
      chk("R10 grant", int'(grant), 0);

      // R8: reference input has no effect outside self-refresh
      vref = 1'b0; step(); step(); chk("R8 wr_ok vref low idle", int'(wr_ok), 1);
      vref = 1'b1;
      // R7: exit request while idle is ignored
      srx = 1'b1; step(); srx = 1'b0; step();
      chk("R7 exit ignored busy", int'(busy), 0);
      chk("R7 exit ignored cke", int'(cke), 1);

      // Sweep of bank patterns and burst lengths: R1 R2 R3 R4 R5
      for (int bu = 0; bu < 4; bu++) begin
         run_rf('0, bu);
         for (int i = 0; i < NB; i++) run_rf(NB'(1) << i, bu);
         run_rf(8'h81, bu);
         run_rf(8'hff, bu);
         run_rf(8'h06, bu);
      end

      // R9: held requests, refresh before self-refresh; then R6 R7 R8
      step(); banks = '0; burst = BW'(1); rreq = 1'b1;
      #1 chk("R11 grant", int'(grant), 1);
      for (int k = 1; k <= 562; k++) begin
         step();
         rreq = (k == 3); sre = (k == 3); srx = (k == 40);
         if (k == 20) vref = 1'b0;
         if (k == 50) vref = 1'b1;
         if (k == 9)  begin chk("R9 idle after first", int'(busy), 0);
                            chk("R9 held refresh granted", int'(grant), 1); end
         if (k == 10) chk("R9 refresh served first", pins(), P_REF);
         if (k == 18) chk("R9 held self-refresh granted", int'(grant), 1);
         if (k == 19) begin chk("R6 entry pins", pins(), P_REF);
                            chk("R6 entry cke low", int'(cke), 0); end
         if (k == 30) begin chk("R6 cke low", int'(cke), 0);
                            chk("R6 DES", int'(cs_n), 1);
                            chk("R8 wr_ok in self-refresh", int'(wr_ok), 0); end
         if (k >= 41 && k <= 45) begin
            chk($sformatf("R7 cke high k=%0d", k), int'(cke), 1);
            chk($sformatf("R7 NOP k=%0d", k), pins(), P_NOP);
            chk($sformatf("R7 act_ok low k=%0d", k), int'(act_ok), 0);
         end
         if (k == 46) begin chk("R7 busy falls", int'(busy), 0);
                            chk("R7 act_ok rises", int'(act_ok), 1);
                            chk("R8 wr_ok still locked", int'(wr_ok), 0); end
         if (k == 561) chk("R8 wr_ok before lockout end", int'(wr_ok), 0);
         if (k == 562) chk("R8 wr_ok at lockout end", int'(wr_ok), 1);
      end
      rreq = 1'b0; sre = 1'b0; srx = 1'b0;

      // R6 R8: single open bank before self-refresh, reference valid early
      step(); banks = 8'h10; sre = 1'b1;
      #1 chk("R11 grant sr", int'(grant), 1);
      for (int k = 1; k <= 706; k++) begin
         step(); sre = 1'b0;
         srx = (k == 700);
         if (k == 6) vref = 1'b0;
         if (k == 8) vref = 1'b1;
         if (k == 1) begin chk("R6 precharge first", pins(), P_PRE);
                           chk("R1 single a10", int'(a10), 0);
                           chk("R1 single ba", int'(ba), 4); end
         if (k == 1 + TRP) begin chk("R6 entry after TRP", pins(), P_REF);
                                 chk("R6 entry cke", int'(cke), 0); end
         if (k == 705) chk("R8 wr_ok gated by act_ok", int'(wr_ok), 0);
         if (k == 706) begin chk("R7 act_ok after TXS", int'(act_ok), 1);
                             chk("R8 wr_ok with early reference", int'(wr_ok), 1); end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule